// File: doc/BRIEF.md
# Time-triggered CAN transmit scheduler

This block decides when a group of seven periodic transmit mailboxes may send in a time-triggered CAN schedule. It takes the running cycle-time count and the basic-cycle number, both produced elsewhere. Each mailbox has two 16-bit trigger words. When a mailbox's trigger time equals the cycle time and its offset agrees with the basic-cycle number, the block issues a one-clock transmit request. The request carries the mailbox index, local 0 to 6, and the window attribute of that mailbox. The frame engine downstream owns arbitration, bit timing and frame assembly.

The periodic mailboxes keep their pending bits across successful sends, so a message goes out again every scheduled period until software cancels it. A repeat factor sets that period to 2^rep basic cycles. A small tracker follows merged arbitrating windows, which open on a "start" entry and close on an "end" entry. It reports an error when an "end" entry appears with no window open.

Top module: `tt_tx_sched`

## Requirements
- R1: When a pending, enabled mailbox has trigger time (word 0) equal to `cyc_time_i`, `tx_req_o` is high for one clock in the cycle after that input. `tx_idx_o` then gives the mailbox index.
- R2: In control word 1, bits 2:0 hold the repeat factor `rep` and bits 13:8 hold the offset. The offset condition holds when the low `rep` bits of the effective basic cycle equal the low `rep` bits of the offset. With `rep = 0` the condition always holds.
- R3: No request is made while `cyc_max_i` is 3'b111 or `timer_run_i` is 0. A mailbox whose 3-bit configuration field is not 3'b000 is never requested.
- R4: The effective basic cycle is `basic_cyc_i` masked to its low `cyc_max_i+1` bits, so the cycle number wraps after 2^(cyc_max_i+1)-1.
- R5: A successful request does not clear the mailbox pending bit in `pend_o`. The same mailbox is requested again at its next matching trigger.
- R6: A `pend_set_i` bit sets the pending bit, visible on `pend_o` one clock later. A `cancel_i` bit clears it, and cancel wins when both arrive in the same clock.
- R7: When several mailboxes match in the same clock, only the lowest index is requested. The others are not requested until a later matching trigger.
- R8: A match fires only on the first clock that `cyc_time_i` takes a new value. A cycle time held for several clocks gives at most one request.
- R9: The window field is control word 1, bits 15:14: 00 exclusive, 01 arbitrating, 10 merged-window start, 11 merged-window end. `win_o` shows the field of the requested mailbox in the request cycle and holds it afterwards.
- R10: `in_merged_o` rises with a request whose window is 10 and falls with a request whose window is 11. Further 10 requests while a window is open keep it set. Requests with window 00 or 01 leave it unchanged.
- R11: A request with window 11 while no merged window is open pulses `merge_err_o` for that one clock, and `in_merged_o` stays 0.
- R12: After reset, `tx_req_o`, `merge_err_o` and `in_merged_o` are 0, `win_o` is 00 and `pend_o` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_time_i | input | 16 | Cycle-time counter value |
| basic_cyc_i | input | 6 | Basic-cycle count |
| cyc_max_i | input | 3 | Cycle-maximum setting, 3'b111 disables the schedule |
| timer_run_i | input | 1 | Cycle timer running |
| trig_time_i | input | 112 | Trigger-time words, mailbox k in bits 16k+15:16k |
| trig_ctrl_i | input | 112 | Trigger-control words, mailbox k in bits 16k+15:16k |
| mb_cfg_i | input | 21 | Mailbox configuration fields, mailbox k in bits 3k+2:3k |
| pend_set_i | input | 7 | Pending set pulses, one per mailbox |
| cancel_i | input | 7 | Cancel pulses, one per mailbox |
| pend_o | output | 7 | Pending bits |
| tx_req_o | output | 1 | One-clock transmit request |
| tx_idx_o | output | 3 | Requested mailbox index |
| win_o | output | 2 | Window attribute of the last request |
| in_merged_o | output | 1 | Inside a merged arbitrating window |
| merge_err_o | output | 1 | Merged-window close with none open |

## Verification
The hardest state to reach is a clock in which the cycle time has just changed and matches several mailboxes at once. Those mailboxes have different repeat factors and offsets, and their merged-window entries mix with the tracker's state. Directed steps first set up shared trigger times, low-bit offset patterns under small cycle-maximum masks, a held cycle time, and open–reopen–close–stray-close window orders. After that, random steps draw the cycle time from a few shared trigger values, so multi-mailbox collisions are common while pending, cancel and enable inputs change.

// File: rtl/tt_sched_pkg.sv
package tt_sched_pkg;
  localparam int WORD_W  = 16;
  localparam int OFF_LSB = 8;
  localparam int OFF_W   = 6;
  localparam int REP_W   = 3;
  localparam int WIN_LSB = 14;
  localparam int CFG_W   = 3;

  typedef enum logic [1:0] {
    WIN_EXCL   = 2'b00,
    WIN_ARB    = 2'b01,
    WIN_MOPEN  = 2'b10,
    WIN_MCLOSE = 2'b11
  } win_e;
endpackage

// File: rtl/tt_mb_match.sv
module tt_mb_match
  import tt_sched_pkg::*;
#(
  parameter int TIME_W = 16
) (
  input  logic [TIME_W-1:0] trig_time_i,
  input  logic [WORD_W-1:0] trig_ctrl_i,
  input  logic [TIME_W-1:0] cyc_time_i,
  input  logic [OFF_W-1:0]  cyc_idx_i,
  input  logic              new_time_i,
  input  logic              sched_en_i,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic              pend_i,
  output logic              hit_o,
  output logic [1:0]        win_o
);
  logic [OFF_W-1:0] off;
  logic [REP_W-1:0] rep;
  logic [OFF_W-1:0] low_mask;
  logic             off_ok;

  assign off      = trig_ctrl_i[OFF_LSB +: OFF_W];
  assign rep      = trig_ctrl_i[REP_W-1:0];
  assign win_o    = trig_ctrl_i[WIN_LSB +: 2];
  // period 2^rep: compare only the low rep bits
  assign low_mask = OFF_W'((32'd1 << rep) - 32'd1);
  assign off_ok   = ((cyc_idx_i ^ off) & low_mask) == '0;

  assign hit_o = sched_en_i && new_time_i && pend_i && (cfg_i == '0)
              && (trig_time_i == cyc_time_i) && off_ok;
endmodule

// File: rtl/tt_prio_pick.sv
module tt_prio_pick #(
  parameter int N = 7,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     gnt_o
);
  always_comb begin
    idx_o = '0;
    gnt_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[k]) begin
        idx_o = IDX_W'(k);
        gnt_o = N'(1) << k;
      end
    end
  end
  assign any_o = |req_i;

  p_onehot_gnt_r7: assert final ($onehot0(gnt_o));
  p_gnt_is_lowest_r7: assert final (gnt_o == (req_i & (~req_i + N'(1))));
endmodule

// File: rtl/tt_merge_track.sv
module tt_merge_track
  import tt_sched_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fire_i,
  input  logic [1:0] win_i,
  output logic       in_merged_o,
  output logic       err_o
);
  logic in_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      err_q <= fire_i && (win_i == WIN_MCLOSE) && !in_q;
      if (fire_i && win_i == WIN_MOPEN)       in_q <= 1'b1;
      else if (fire_i && win_i == WIN_MCLOSE) in_q <= 1'b0;
    end
  end

  assign in_merged_o = in_q;
  assign err_o       = err_q;

  p_err_no_window_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> (!in_q && !$past(in_q)));
  p_excl_arb_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && !win_i[1]) |=> $stable(in_q));
endmodule

// File: rtl/tt_tx_sched.sv
module tt_tx_sched
  import tt_sched_pkg::*;
#(
  parameter int NUM_MB = 7,
  parameter int TIME_W = 16,
  parameter int CMAX_W = 3,
  localparam int IDX_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [TIME_W-1:0]          cyc_time_i,
  input  logic [OFF_W-1:0]           basic_cyc_i,
  input  logic [CMAX_W-1:0]          cyc_max_i,
  input  logic                       timer_run_i,
  input  logic [NUM_MB*TIME_W-1:0]   trig_time_i,
  input  logic [NUM_MB*WORD_W-1:0]   trig_ctrl_i,
  input  logic [NUM_MB*CFG_W-1:0]    mb_cfg_i,
  input  logic [NUM_MB-1:0]          pend_set_i,
  input  logic [NUM_MB-1:0]          cancel_i,
  output logic [NUM_MB-1:0]          pend_o,
  output logic                       tx_req_o,
  output logic [IDX_W-1:0]           tx_idx_o,
  output logic [1:0]                 win_o,
  output logic                       in_merged_o,
  output logic                       merge_err_o
);
  logic [TIME_W-1:0]           prev_time_q;
  logic                        prev_vld_q;
  logic                        new_time, sched_en;
  logic [OFF_W-1:0]            cyc_mask, cyc_idx;
  logic [NUM_MB-1:0]           pend_q, hit, gnt;
  logic [NUM_MB-1:0][1:0]      win_vec;
  logic                        any_hit;
  logic [IDX_W-1:0]            pick_idx;
  logic [1:0]                  pick_win;
  logic                        req_q;
  logic [IDX_W-1:0]            idx_q;
  logic [1:0]                  win_q;

  assign new_time = !prev_vld_q || (cyc_time_i != prev_time_q);
  assign sched_en = (cyc_max_i != '1) && timer_run_i;
  assign cyc_mask = OFF_W'((32'd1 << ({{(32-CMAX_W){1'b0}}, cyc_max_i} + 32'd1)) - 32'd1);
  assign cyc_idx  = basic_cyc_i & cyc_mask;

  for (genvar k = 0; k < NUM_MB; k++) begin : g_mb
    tt_mb_match #(.TIME_W(TIME_W)) u_match (
      .trig_time_i (trig_time_i[k*TIME_W +: TIME_W]),
      .trig_ctrl_i (trig_ctrl_i[k*WORD_W +: WORD_W]),
      .cyc_time_i  (cyc_time_i),
      .cyc_idx_i   (cyc_idx),
      .new_time_i  (new_time),
      .sched_en_i  (sched_en),
      .cfg_i       (mb_cfg_i[k*CFG_W +: CFG_W]),
      .pend_i      (pend_q[k]),
      .hit_o       (hit[k]),
      .win_o       (win_vec[k])
    );
  end

  tt_prio_pick #(.N(NUM_MB)) u_pick (
    .req_i (hit),
    .any_o (any_hit),
    .idx_o (pick_idx),
    .gnt_o (gnt)
  );

  always_comb begin
    pick_win = WIN_EXCL;
    for (int k = 0; k < NUM_MB; k++) if (gnt[k]) pick_win = win_vec[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_time_q <= '0;
      prev_vld_q  <= 1'b0;
      pend_q      <= '0;
      req_q       <= 1'b0;
      idx_q       <= '0;
      win_q       <= WIN_EXCL;
    end else begin
      prev_time_q <= cyc_time_i;
      prev_vld_q  <= 1'b1;
      // periodic mailboxes: a send never clears pending
      pend_q      <= (pend_q | pend_set_i) & ~cancel_i;
      req_q       <= any_hit;
      if (any_hit) begin
        idx_q <= pick_idx;
        win_q <= pick_win;
      end
    end
  end

  tt_merge_track u_merge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fire_i      (any_hit),
    .win_i       (pick_win),
    .in_merged_o (in_merged_o),
    .err_o       (merge_err_o)
  );

  assign pend_o   = pend_q;
  assign tx_req_o = req_q;
  assign tx_idx_o = idx_q;
  assign win_o    = win_q;

  p_disabled_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_max_i == '1 || !timer_run_i) |=> !tx_req_o);
  p_stall_once_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_req_o && cyc_time_i == prev_time_q) |=> !tx_req_o);
  p_cancel_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cancel_i != '0) |=> ((pend_q & $past(cancel_i)) == '0));
  p_send_keeps_pend_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_hit && !cancel_i[pick_idx]) |=> pend_q[tx_idx_o]);
endmodule

// File: tb/tt_tx_sched_test.sv
module tt_tx_sched_test;
  localparam int N = 7;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [15:0]      ct = '0;
  logic [5:0]       bc = '0;
  logic [2:0]       cmax = 3'd5;
  logic             run = 1'b1;
  logic [15:0]      tt [N];
  logic [15:0]      tc [N];
  logic [2:0]       cf [N];
  logic [N-1:0]     pset = '0, canc = '0;
  logic [N*16-1:0]  tt_flat, tc_flat;
  logic [N*3-1:0]   cf_flat;
  logic [N-1:0]     pend;
  logic             req, inm, merr;
  logic [2:0]       idx;
  logic [1:0]       win;

  int total = 0, bad = 0;
  logic [N-1:0] m_pend = '0;
  logic [15:0]  m_prev = '0;
  logic         m_vld = 1'b0, m_in = 1'b0, m_err = 1'b0, m_req = 1'b0;
  logic [2:0]   m_idx = '0;
  logic [1:0]   m_win = '0;

  always #10 clk = ~clk;

  always_comb for (int k = 0; k < N; k++) begin
    tt_flat[k*16 +: 16] = tt[k];
    tc_flat[k*16 +: 16] = tc[k];
    cf_flat[k*3 +: 3]   = cf[k];
  end

  tt_tx_sched uut (
    .clk_i(clk), .rst_ni(rst_n), .cyc_time_i(ct), .basic_cyc_i(bc),
    .cyc_max_i(cmax), .timer_run_i(run), .trig_time_i(tt_flat),
    .trig_ctrl_i(tc_flat), .mb_cfg_i(cf_flat), .pend_set_i(pset),
    .cancel_i(canc), .pend_o(pend), .tx_req_o(req), .tx_idx_o(idx),
    .win_o(win), .in_merged_o(inm), .merge_err_o(merr)
  );

  function automatic logic [15:0] ctrl(logic [1:0] w, logic [5:0] off, logic [2:0] rep);
    return {w, off, 5'd0, rep};
  endfunction

  function automatic logic elig(int k);
    logic [5:0] cm, lm;
    cm = 6'((32'd1 << (cmax + 32'd1)) - 1);
    lm = 6'((32'd1 << tc[k][2:0]) - 1);
    return cmax != 3'b111 && run && cf[k] == 3'd0 && m_pend[k] && tt[k] == ct
        && (!m_vld || ct != m_prev) && ((((bc & cm) ^ tc[k][13:8]) & lm) == 6'd0);
  endfunction

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // one clock: model predicts, design is sampled at the next falling edge
  task automatic tick(string tag);
    logic [1:0] w;
    m_req = 1'b0;
    for (int k = N - 1; k >= 0; k--) if (elig(k)) begin m_req = 1'b1; m_idx = 3'(k); end
    m_err = 1'b0;
    if (m_req) begin
      w = tc[m_idx][15:14];
      m_win = w;
      if (w == 2'b10) m_in = 1'b1;
      else if (w == 2'b11) begin m_err = !m_in; m_in = 1'b0; end
    end
    m_prev = ct; m_vld = 1'b1;
    m_pend = (m_pend | pset) & ~canc;
    @(posedge clk); @(negedge clk);
    chk({tag, " req"}, 16'(req), 16'(m_req));
    if (m_req) chk({tag, " idx"}, 16'(idx), 16'(m_idx));
    chk({tag, " win"}, 16'(win), 16'(m_win));
    chk({tag, " merged"}, 16'(inm), 16'(m_in));
    chk({tag, " err"}, 16'(merr), 16'(m_err));
    chk({tag, " pend"}, 16'(pend), 16'(m_pend));
    pset = '0; canc = '0;
  endtask

  task automatic fire_at(string tag, logic [15:0] t);
    ct = t ^ 16'h8000; tick(tag);
    ct = t; tick(tag);
  endtask

  initial begin
    #3_000_000;
    bad++;
    $display("FAIL watchdog got=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int k = 0; k < N; k++) begin tt[k] = 16'hffff; tc[k] = '0; cf[k] = '0; end
    @(negedge clk); @(negedge clk);
    chk("R12 req", 16'(req), 16'd0); chk("R12 pend", 16'(pend), 16'd0);
    chk("R12 win", 16'(win), 16'd0); chk("R12 merged", 16'(inm), 16'd0);
    chk("R12 err", 16'(merr), 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1/R5/R6: single mailbox
    tt[2] = 16'd100; tc[2] = ctrl(2'b01, 6'd0, 3'd0);
    pset = 7'b0000100; tick("R6 set");
    chk("R6 set", 16'(pend[2]), 16'd1);
    fire_at("R1", 16'd100);
    chk("R1 req", 16'(req), 16'd1); chk("R1 idx", 16'(idx), 16'd2);
    chk("R9 win", 16'(win), 16'd1); chk("R5 pend kept", 16'(pend[2]), 16'd1);
    tick("R8 hold");
    chk("R8 no repeat", 16'(req), 16'd0);
    fire_at("R5", 16'd100);
    chk("R5 again", 16'(req), 16'd1);

    // R3: enables
    cmax = 3'b111; fire_at("R3 cmax", 16'd100); chk("R3 cmax", 16'(req), 16'd0);
    cmax = 3'd5; run = 1'b0; fire_at("R3 run", 16'd100); chk("R3 run", 16'(req), 16'd0);
    run = 1'b1; cf[2] = 3'd1; fire_at("R3 cfg", 16'd100); chk("R3 cfg", 16'(req), 16'd0);
    cf[2] = 3'd0;

    // R2/R4: offset with repeat factor and mask
    tc[2] = ctrl(2'b00, 6'd1, 3'd2); cmax = 3'd1;
    bc = 6'd5; fire_at("R2", 16'd100); chk("R2 match", 16'(req), 16'd1);
    bc = 6'd6; fire_at("R2", 16'd100); chk("R2 miss", 16'(req), 16'd0);
    cmax = 3'd0; bc = 6'd3; fire_at("R4", 16'd100); chk("R4 wrap", 16'(req), 16'd1);
    cmax = 3'd1; bc = 6'd3; fire_at("R4", 16'd100); chk("R4 nowrap", 16'(req), 16'd0);
    cmax = 3'd5; bc = 6'd0;

    // R7: collision
    tt[4] = 16'd200; tt[5] = 16'd200; tc[4] = ctrl(2'b00, 0, 0); tc[5] = ctrl(2'b01, 0, 0);
    pset = 7'b0110000; tick("R7 set");
    fire_at("R7", 16'd200); chk("R7 idx", 16'(idx), 16'd4); chk("R7 req", 16'(req), 16'd1);
    canc = 7'b0010000; tick("R6 cancel");
    fire_at("R7 next", 16'd200); chk("R7 next idx", 16'(idx), 16'd5);

    // R10/R11: merged windows
    tt[1] = 16'd300; tc[1] = ctrl(2'b10, 0, 0);
    tt[3] = 16'd310; tc[3] = ctrl(2'b10, 0, 0);
    tt[6] = 16'd320; tc[6] = ctrl(2'b11, 0, 0);
    pset = 7'b1001010; tick("R10 set");
    fire_at("R10", 16'd300); chk("R10 open", 16'(inm), 16'd1);
    fire_at("R10", 16'd310); chk("R10 reopen", 16'(inm), 16'd1);
    fire_at("R10", 16'd320); chk("R10 close", 16'(inm), 16'd0);
    chk("R11 no err", 16'(merr), 16'd0);
    fire_at("R11", 16'd320); chk("R11 err", 16'(merr), 16'd1); chk("R11 merged", 16'(inm), 16'd0);
    tick("R11 pulse"); chk("R11 pulse", 16'(merr), 16'd0);

    // R6: set and cancel together
    pset = 7'b0000001; canc = 7'b0000001; tick("R6 both");
    chk("R6 cancel wins", 16'(pend[0]), 16'd0);

    // random mix
    for (int k = 0; k < N; k++) begin
      tt[k] = 16'd10 * 16'(1 + $urandom_range(0, 2));
      tc[k] = ctrl(2'($urandom), 6'($urandom), 3'($urandom_range(0, 3)));
      cf[k] = ($urandom_range(0, 7) == 0) ? 3'd2 : 3'd0;
    end
    for (int i = 0; i < 3000; i++) begin
      ct   = 16'd10 * 16'($urandom_range(0, 3));
      bc   = 6'($urandom);
      cmax = ($urandom_range(0, 15) == 0) ? 3'b111 : 3'($urandom_range(0, 6));
      run  = $urandom_range(0, 15) != 0;
      pset = 7'($urandom) & 7'($urandom);
      canc = ($urandom_range(0, 7) == 0) ? 7'($urandom) : 7'd0;
      tick("R1 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule